// File: doc/BRIEF.md
# Serial Word Deserializer with Control-Bit Voting

This block sits behind a bit-clock recovery stage and turns a stream of serial bits back into parallel words. Each word is 20 bits long and arrives least significant bit first. An alignment strobe marks the first bit of a word. After one strobe the framing runs free, and every later strobe restarts it. Each finished word is looked up against two fixed transition patterns. A transition word switches the block between its video phase and its control phase. Every other word is decoded according to the current phase.

In the video phase a word yields 18 symbol bits. The symbols are inverted back when the word's inversion flag is set. In the control phase a word yields nine control bits. The first five are each sent three times and are rebuilt by a two-of-three vote, so one corrupted copy does no harm. The last four are sent once and pass straight through. A one-cycle valid pulse goes with each decoded word, and data-enable tells which kind of word it was. A test flag reports any control triplet whose copies disagree.

The framer has two states. In `FR_HUNT` bits are ignored, and a strobe moves it to `FR_LOCK`. `FR_LOCK` holds until reset. The phase machine has two states. `PH_CTRL` moves to `PH_VIDEO` on the to-video pattern. `PH_VIDEO` moves to `PH_CTRL` on the to-control pattern. A pattern that matches the current phase is consumed and leaves the phase unchanged.

Top module: `serial_word_deser`

## Requirements
- R1: A word occupies 20 consecutive bit cycles, LSB first. The edge that samples its last bit registers the decoded outputs, and `word_valid` is high for exactly that one following cycle.
- R2: Before the first strobe after reset, no word is delivered. Once a strobe has been seen, words follow back to back every 20 cycles with no further strobe.
- R3: `word_strobe` marks bit 0 of a new word and discards any partial word. This also holds when the strobe lands on the cycle that would have carried bit 19 of the previous word; that word is then not delivered.
- R4: Word value 20'h3E0F1 is the to-video transition and 20'hC1F0E is the to-control transition. Both are recognised in either phase. A transition word raises no `word_valid`, and all data outputs keep their values.
- R5: In a control word, `ctrl_out[k]` for k = 0..4 is the majority of word bits 3k+1, 3k+2 and 3k+3.
- R6: In a control word, `ctrl_out[5+j]` for j = 0..3 equals word bit 16+j with no voting. Word bit 0 has no effect on any output.
- R7: In a video word, `video_out` is word bits 19:2, inverted when word bit 1 is 1. `ctrl_out` keeps its value.
- R8: With each valid word, `data_en` is 1 for a video word and 0 for a control word, and it changes at no other time. Reset leaves the block in the control phase.
- R9: `ctrl_err` is high together with the valid of a control word in which any triplet has copies that disagree. It is low at all other times.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_bit | input | 1 | Serial data bit |
| word_strobe | input | 1 | High with bit 0 of a word |
| video_out | output | 18 | Recovered video symbols |
| ctrl_out | output | 9 | Recovered control bits |
| data_en | output | 1 | 1 for a video word, 0 for a control word |
| word_valid | output | 1 | One-cycle pulse per decoded word |
| ctrl_err | output | 1 | Control triplet disagreement seen in this word |

## Verification
Realignment and word completion can fall in the same cycle, when a strobe arrives exactly where bit 19 of a running word would be sampled. The bench provokes this by stopping a video word after 19 bits and starting a strobed word in the next cycle. It counts as correct when no valid pulse appears anywhere before the new word's twentieth bit, and the new word then decodes to its own arithmetic value. The bench also restarts a word after only 7 bits, and it injects single and double errors into every voted position across a sweep of control values.

// File: rtl/deser_pkg.sv
package deser_pkg;

    typedef enum logic {FR_HUNT, FR_LOCK} frame_st_t;

    typedef enum logic {PH_CTRL, PH_VIDEO} phase_st_t;

    function automatic logic maj3(input logic [2:0] t);
        return (t[0] & t[1]) | (t[0] & t[2]) | (t[1] & t[2]);
    endfunction

endpackage

// File: rtl/deser_shift.sv
module deser_shift
    import deser_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_bit,
    input  logic              word_strobe,
    output logic              word_done,
    output logic [WORD_W-1:0] word_data
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    frame_st_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_HUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT: if (word_strobe) state_d = FR_LOCK;
            FR_LOCK: state_d = FR_LOCK;
            default: state_d = FR_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            shr_q <= '0;
        end else begin
            shr_q <= {ser_bit, shr_q[WORD_W-1:1]};
            if (word_strobe)
                cnt_q <= CNT_W'(1);
            else if (state_q == FR_LOCK)
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign word_done = (state_q == FR_LOCK) && !word_strobe && (cnt_q == LAST);
    assign word_data = {ser_bit, shr_q[WORD_W-1:1]};

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < WORD_W); // R1
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FR_HUNT) |-> !word_done); // R2
    AST_STROBE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        word_strobe |=> (cnt_q == CNT_W'(1))); // R3

endmodule

// File: rtl/deser_vote.sv
module deser_vote
    import deser_pkg::*;
#(
    parameter int NUM_VOTED  = 5,
    parameter int NUM_SINGLE = 4
) (
    input  logic [3*NUM_VOTED+NUM_SINGLE-1:0] body,
    output logic [NUM_VOTED+NUM_SINGLE-1:0]   ctrl,
    output logic                              disagree
);
    localparam int SINGLE_BASE = 3 * NUM_VOTED;

    logic [NUM_VOTED-1:0] mismatch;

    for (genvar k = 0; k < NUM_VOTED; k++) begin : g_voted
        logic [2:0] trip;
        assign trip        = body[3*k +: 3];
        assign ctrl[k]     = maj3(trip);
        assign mismatch[k] = (trip != 3'b000) && (trip != 3'b111);
    end

    for (genvar j = 0; j < NUM_SINGLE; j++) begin : g_single
        assign ctrl[NUM_VOTED+j] = body[SINGLE_BASE+j];
    end

    assign disagree = |mismatch;

endmodule

// File: rtl/deser_video.sv
module deser_video #(
    parameter int VID_W = 18
) (
    input  logic [VID_W:0]   body,
    output logic [VID_W-1:0] vid
);
    assign vid = body[VID_W:1] ^ {VID_W{body[0]}};
endmodule

// File: rtl/serial_word_deser.sv
module serial_word_deser
    import deser_pkg::*;
#(
    parameter int                 VID_W        = 18,
    parameter int                 NUM_VOTED    = 5,
    parameter int                 NUM_SINGLE   = 4,
    parameter logic [VID_W+1:0]   TRN_TO_VIDEO = 20'h3E0F1,
    parameter logic [VID_W+1:0]   TRN_TO_CTRL  = 20'hC1F0E
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_bit,
    input  logic                          word_strobe,
    output logic [VID_W-1:0]              video_out,
    output logic [NUM_VOTED+NUM_SINGLE-1:0] ctrl_out,
    output logic                          data_en,
    output logic                          word_valid,
    output logic                          ctrl_err
);
    localparam int WORD_W = VID_W + 2;
    localparam int CTRL_W = NUM_VOTED + NUM_SINGLE;

    logic              word_done;
    logic [WORD_W-1:0] word_data;
    logic [CTRL_W-1:0] ctrl_dec;
    logic              disagree;
    logic [VID_W-1:0]  vid_dec;
    logic              is_to_vid, is_to_ctl, is_trn, take;

    phase_st_t phase_q, phase_d;

    deser_shift #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .word_strobe(word_strobe),
        .word_done(word_done), .word_data(word_data)
    );

    deser_vote #(.NUM_VOTED(NUM_VOTED), .NUM_SINGLE(NUM_SINGLE)) u_vote (
        .body(word_data[WORD_W-1:1]), .ctrl(ctrl_dec), .disagree(disagree)
    );

    deser_video #(.VID_W(VID_W)) u_video (
        .body(word_data[WORD_W-1:1]), .vid(vid_dec)
    );

    assign is_to_vid = word_done && (word_data == TRN_TO_VIDEO);
    assign is_to_ctl = word_done && (word_data == TRN_TO_CTRL);
    assign is_trn    = is_to_vid || is_to_ctl;
    assign take      = word_done && !is_trn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_CTRL;
        else        phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_CTRL:  if (is_to_vid) phase_d = PH_VIDEO;
            PH_VIDEO: if (is_to_ctl) phase_d = PH_CTRL;
            default:  phase_d = PH_CTRL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            video_out  <= '0;
            ctrl_out   <= '0;
            data_en    <= 1'b0;
            word_valid <= 1'b0;
            ctrl_err   <= 1'b0;
        end else begin
            word_valid <= take;
            ctrl_err   <= 1'b0;
            if (take) begin
                unique case (phase_q)
                    PH_VIDEO: begin
                        video_out <= vid_dec;
                        data_en   <= 1'b1;
                    end
                    PH_CTRL: begin
                        ctrl_out <= ctrl_dec;
                        ctrl_err <= disagree;
                        data_en  <= 1'b0;
                    end
                    default: data_en <= 1'b0;
                endcase
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R1
    AST_VALID_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(word_done)); // R1
    AST_TRN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_trn) |-> (!word_valid && $stable(video_out) && $stable(ctrl_out))); // R4
    AST_CTRL_HOLD_IN_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && data_en) |-> $stable(ctrl_out)); // R7
    AST_DE_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_en) |-> word_valid); // R8
    AST_ERR_ONLY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err |-> (word_valid && !data_en)); // R9

endmodule

// File: tb/test_serial_word_deser.sv
module test_serial_word_deser;

    localparam logic [19:0] TV = 20'h3E0F1;
    localparam logic [19:0] TC = 20'hC1F0E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bit = 1'b0;
    logic        word_strobe = 1'b0;
    logic [17:0] video_out;
    logic [8:0]  ctrl_out;
    logic        data_en, word_valid, ctrl_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit early;

    serial_word_deser i_serial_word_deser (
        .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .word_strobe(word_strobe),
        .video_out(video_out), .ctrl_out(ctrl_out), .data_en(data_en),
        .word_valid(word_valid), .ctrl_err(ctrl_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 'h%0h, expected 'h%0h", tag, act, exp);
        end
    endtask

    function automatic logic [19:0] ctrl_word(input logic [8:0] c, input logic en0);
        logic [19:0] w;
        w[0] = en0;
        for (int k = 0; k < 5; k++) w[3*k+1 +: 3] = {3{c[k]}};
        for (int j = 0; j < 4; j++) w[16+j] = c[5+j];
        if (w == TV || w == TC) w[0] = ~w[0];
        return w;
    endfunction

    function automatic logic [19:0] video_word(input logic [17:0] v, input logic inv, input logic en0);
        logic [19:0] w;
        w = {v ^ {18{inv}}, inv, en0};
        if (w == TV || w == TC) w[0] = ~w[0];
        return w;
    endfunction

    // sends one word; afterwards outputs of its last edge are visible
    task automatic send_word(input logic [19:0] w, input bit strb);
        early = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ser_bit = w[i];
            word_strobe = strb && (i == 0);
            @(posedge clk);
            #1;
            if (i < 19 && word_valid) early = 1'b1;
        end
    endtask

    task automatic send_partial(input logic [19:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ser_bit = w[i];
            word_strobe = 1'b0;
        end
    endtask

    task automatic chk_ctrl(input logic [8:0] c, input logic err, input string tag);
        chk(word_valid && !early, {tag, " valid"}, int'(word_valid), 1);
        chk(ctrl_out == c, {tag, " ctrl"}, int'(ctrl_out), int'(c));
        chk(data_en == 1'b0, {tag, " R8 de"}, int'(data_en), 0);
        chk(ctrl_err == err, {tag, " R9 err"}, int'(ctrl_err), int'(err));
    endtask

    initial begin
        logic [8:0]  c, last_c;
        logic [17:0] v;
        logic [19:0] w;

        repeat (4) @(posedge clk);
        #1;
        chk(video_out == 0 && ctrl_out == 0 && !data_en && !word_valid && !ctrl_err,
            "R10 reset", int'({video_out, ctrl_out}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: no strobe yet, nothing delivered
        send_word(ctrl_word(9'h1A5, 1'b0), 1'b0);
        chk(!word_valid && !early, "R2 hunt", int'(word_valid), 0);

        // R5 R6 R2: full control sweep, strobe only on the first word
        for (int n = 0; n < 512; n++) begin
            c = 9'(n);
            send_word(ctrl_word(c, 1'(n >> 3)), n == 0);
            chk_ctrl(c, 1'b0, "R5 sweep");
        end

        // single errors in voted copies (R5 R9), in single bits (R6), bit 0 (R6)
        for (int pos = 0; pos < 20; pos++) begin
            for (int n = 0; n < 32; n++) begin
                c = 9'((pos * 97 + n * 17) & 511);
                w = ctrl_word(c, 1'b0);
                w[pos] = ~w[pos];
                send_word(w, 1'b0);
                if (pos == 0)
                    chk_ctrl(c, 1'b0, "R6 en0 ignored");
                else if (pos <= 15)
                    chk_ctrl(c, 1'b1, "R5 single error");
                else
                    chk_ctrl(c ^ (9'd1 << (pos - 11)), 1'b0, "R6 direct bit");
            end
        end

        // double errors in each triplet flip the vote
        for (int k = 0; k < 5; k++) begin
            for (int n = 0; n < 8; n++) begin
                c = 9'((k * 61 + n * 43) & 511);
                w = ctrl_word(c, 1'b1);
                w[3*k+1] = ~w[3*k+1];
                w[3*k+3] = ~w[3*k+3];
                send_word(w, 1'b0);
                chk_ctrl(c ^ (9'd1 << k), 1'b1, "R5 double error");
            end
        end
        last_c = ctrl_out;

        // R4: to-control pattern in control phase is silent
        send_word(TC, 1'b0);
        chk(!word_valid && !early && ctrl_out == last_c && !data_en, "R4 trn same phase",
            int'(ctrl_out), int'(last_c));

        // R4: enter video phase
        send_word(TV, 1'b0);
        chk(!word_valid && !early && ctrl_out == last_c && !data_en, "R4 trn to video",
            int'(word_valid), 0);

        // R7 R8: video sweep with and without inversion
        for (int n = 0; n < 512; n++) begin
            v = 18'((n * 32'h2F3A1) ^ (n << 9));
            send_word(video_word(v, 1'(n), 1'(n >> 1)), 1'b0);
            chk(word_valid && !early, "R1 video valid", int'(word_valid), 1);
            chk(video_out == v, "R7 video", int'(video_out), int'(v));
            chk(data_en == 1'b1, "R8 de video", int'(data_en), 1);
            chk(ctrl_out == last_c && !ctrl_err, "R7 ctrl hold", int'(ctrl_out), int'(last_c));
        end

        // R3: strobe where bit 19 would land
        v = 18'h2B4C7;
        send_partial(video_word(18'h15555, 1'b0, 1'b0), 19);
        send_word(video_word(v, 1'b1, 1'b0), 1'b1);
        chk(!early, "R3 collide no valid", int'(early), 0);
        chk(word_valid && video_out == v, "R3 collide word", int'(video_out), int'(v));

        // R3: restart after 7 bits
        v = 18'h0F0F3;
        send_partial(video_word(18'h3FFFF, 1'b1, 1'b1), 7);
        send_word(video_word(v, 1'b0, 1'b1), 1'b1);
        chk(!early && word_valid && video_out == v, "R3 mid restart", int'(video_out), int'(v));

        // R4: to-video pattern in video phase, then back to control
        send_word(TV, 1'b0);
        chk(!word_valid && video_out == v && data_en, "R4 trn video same", int'(video_out), int'(v));
        send_word(TC, 1'b0);
        chk(!word_valid && video_out == v && data_en, "R4 trn to ctrl", int'(data_en), 1);
        send_word(ctrl_word(9'h0C3, 1'b0), 1'b0);
        chk_ctrl(9'h0C3, 1'b0, "R8 back to ctrl");
        chk(video_out == v, "R7 video hold", int'(video_out), int'(v));

        // R1: valid lasts one cycle
        @(posedge clk);
        #1;
        chk(!word_valid, "R1 pulse width", int'(word_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule